// File: doc/BRIEF.md
# Dual-Source UART Baud Generator

This block produces the bit-rate tick enable for a UART. A single 25-bit configuration register holds a 23-bit divisor, an enable flag and a source select. Two source enables arrive from the surrounding chip, both in the one clock domain of the block: a main baud-clock enable and a crystal-derived enable. Each source has its own fixed prescaler: the main path divides by 4 and the crystal path divides by 3. The selected prescaler output is then divided by (divisor + 1). Every completed division yields a tick that is one clock cycle wide.

Software programs the divisor from the wanted rate. On the crystal path the value is source_rate / 3 / baud - 1. On the main path it is source_rate / (4 * baud), rounded to the nearest integer, minus 1. Rates from 50 to 4,000,000 baud are covered by the 23-bit field. The register is written through a simple write strobe at byte address 0x14 and is always visible on a readback port.

Changes are glitch-free. The running generator works from a shadow copy of divisor and source select. That copy is refreshed only at a tick boundary, so no period is cut short or stretched by a write that lands mid-period.

Top module: `baudgen_dual_src`

## Requirements
- R1: After reset the readback port reads 0 and no tick is produced.
- R2: A write strobe at address 0x14 stores the data bits as follows: divisor in bits 22:0, enable flag in bit 23, crystal-select flag in bit 24 (1 = crystal path, 0 = main path). The readback port returns exactly the stored 25 bits.
- R3: A write to any other address, or address 0x14 with the strobe low, leaves the register unchanged.
- R4: While the enable flag is 0, no tick is produced, whatever the source enables do.
- R5: On the main path with divisor D, one tick is produced for every 4*(D+1) main enables.
- R6: On the crystal path with divisor D, one tick is produced for every 3*(D+1) crystal enables. Main enables have no effect while the crystal path is selected.
- R7: After a write that sets the enable flag at clock edge e, only enables of the selected source seen at edges later than e+1 are counted. The tick is high in the cycle after the edge that carries the counted enable which completes the period.
- R8: The tick is never high in two consecutive cycles.
- R9: A divisor or source change written while the generator runs takes effect only after the next tick. The period in progress keeps the old setting.
- R10: Divisor 0 gives the shortest period: one tick per prescale count of source enables (4 main, 3 crystal).
- R11: Clearing the enable flag stops ticks from the next edge on. A later re-enable restarts counting from zero, as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 25 | Write data |
| main_ce | input | 1 | Main baud-clock enable |
| xtal_ce | input | 1 | Crystal-derived enable |
| rd_data | output | 25 | Register readback |
| tick | output | 1 | One-cycle baud tick |

## Verification
The register is written at an edge the bench numbers e. The readback is valid in the same cycle, just after e. The generator counts selected enables only from edge e+2. The tick is registered, so it rises in the cycle after the edge that carries the completing enable. The bench drives each source enable so that it is seen only at edges that are multiples of a chosen spacing. From that rule it computes the exact edge number of every expected tick and queues it. A monitor samples on the falling edge and compares the running edge count with the front of the queue. Any tick it sees when the queue is empty counts as a miscompare against the disabled-state requirement that is active at the time.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  typedef enum logic {
    SRC_MAIN = 1'b0,
    SRC_XTAL = 1'b1
  } src_e;

  // Fixed prescale belonging to a source path index (1 = crystal path).
  function automatic int unsigned prescale_of(input int unsigned src_idx,
                                              input int unsigned main_pre,
                                              input int unsigned xtal_pre);
    return (src_idx == 1) ? xtal_pre : main_pre;
  endfunction

  // Counter width able to hold 0 .. n-1, never narrower than one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Source enables per tick for a prescale and a divisor value.
  function automatic longint unsigned enables_per_tick(input int unsigned pre,
                                                       input longint unsigned div);
    return longint'(pre) * (div + 1);
  endfunction

endpackage

// File: rtl/baudgen_regs.sv
module baudgen_regs #(
  parameter int unsigned DIV_W = 23,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h14,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data,
  output logic [DIV_W-1:0]  cfg_div,
  output logic              cfg_use,
  output logic              cfg_sel
);
  localparam int unsigned USE_BIT = DIV_W;
  localparam int unsigned SEL_BIT = DIV_W + 1;

  logic [REG_W-1:0] reg_q;
  logic             hit;

  assign hit = wr_en && (wr_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   reg_q <= '0;
    else if (hit) reg_q <= wr_data;
  end

  assign rd_data = reg_q;
  assign cfg_div = reg_q[DIV_W-1:0];
  assign cfg_use = reg_q[USE_BIT];
  assign cfg_sel = reg_q[SEL_BIT];

  // R3
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(reg_q));

endmodule

// File: rtl/baudgen_prescale.sv
module baudgen_prescale #(
  parameter int unsigned PRE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic active,
  output logic wrap
);
  localparam int unsigned CW = baudgen_pkg::cnt_width(PRE);
  localparam logic [CW-1:0] LAST = CW'(PRE - 1);

  logic [CW-1:0] cnt;

  assign wrap = active && en && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!active) cnt <= '0;
    else if (en)     cnt <= wrap ? '0 : cnt + 1'b1;
  end

  // R5 R6
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

endmodule

// File: rtl/baudgen_divider.sv
module baudgen_divider #(
  parameter int unsigned DIV_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             step,
  input  logic [DIV_W-1:0] limit,
  output logic             fire
);
  logic [DIV_W-1:0] cnt;

  assign fire = go && step && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (!go) cnt <= '0;
    else if (step) cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end

  // R9
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> cnt <= limit);

endmodule

// File: rtl/baudgen_dual_src.sv
module baudgen_dual_src #(
  parameter int unsigned DIV_W = 23,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h14,
  parameter int unsigned MAIN_PRE = 4,
  parameter int unsigned XTAL_PRE = 3,
  localparam int unsigned REG_W = DIV_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              main_ce,
  input  logic              xtal_ce,
  output logic [REG_W-1:0]  rd_data,
  output logic              tick
);
  import baudgen_pkg::*;

  localparam int unsigned NSRC = 2;

  logic [DIV_W-1:0] cfg_div;
  logic             cfg_use;
  logic             cfg_sel;

  logic             running_q;
  logic [DIV_W-1:0] act_div;
  src_e             act_sel;
  logic             go;
  logic [NSRC-1:0]  src_en;
  logic [NSRC-1:0]  wrap;
  logic             step;
  logic             fire;
  logic             tick_q;

  baudgen_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .cfg_div(cfg_div), .cfg_use(cfg_use), .cfg_sel(cfg_sel)
  );

  // Counting runs only once the shadow copy is loaded and the flag is still set.
  assign go     = running_q && cfg_use;
  assign src_en = {xtal_ce, main_ce};

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    localparam int unsigned PRE = prescale_of(gi, MAIN_PRE, XTAL_PRE);
    localparam src_e        ME  = (gi == 1) ? SRC_XTAL : SRC_MAIN;
    baudgen_prescale #(.PRE(PRE)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(src_en[gi]),
      .active(go && (act_sel == ME)), .wrap(wrap[gi])
    );
  end

  assign step = (act_sel == SRC_XTAL) ? wrap[1] : wrap[0];

  baudgen_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(go), .step(step), .limit(act_div), .fire(fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q <= 1'b0;
      act_div   <= '0;
      act_sel   <= SRC_MAIN;
      tick_q    <= 1'b0;
    end else begin
      running_q <= cfg_use;
      if ((cfg_use && !running_q) || fire) begin
        act_div <= cfg_div;
        act_sel <= src_e'(cfg_sel);
      end
      tick_q <= fire;
    end
  end

  assign tick = tick_q;

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R4 R11
  no_tick_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_use |=> !tick);

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && $past(go) && !$past(fire)) |-> ($stable(act_div) && $stable(act_sel)));

  // R7
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running_q) |-> !tick);

endmodule

// File: tb/baudgen_dual_src_tb.sv
module baudgen_dual_src_tb;
  localparam int REG_W = 25;
  localparam logic [7:0] ADDR = 8'h14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [REG_W-1:0] wr_data = '0;
  logic main_ce = 1'b0;
  logic xtal_ce = 1'b0;
  logic [REG_W-1:0] rd_data;
  logic tick;

  baudgen_dual_src u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .main_ce(main_ce), .xtal_ce(xtal_ce), .rd_data(rd_data), .tick(tick)
  );

  always #10 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Enables are seen only at edges whose number is a multiple of the spacing.
  longint km = 1;
  longint kx = 1;
  always @(negedge clk) begin
    main_ce = ((cyc + 1) % km) == 0;
    xtal_ce = ((cyc + 1) % kx) == 0;
  end

  int n_chk = 0;
  int n_fail = 0;
  longint exp_q[$];
  string tag_q[$];
  string quiet_tag = "R1";
  int tick_seen = 0;
  logic prev_tick = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard whenever a tick shows up.
  always @(negedge clk) begin : mon
    longint e;
    string t;
    if (rst_n && tick) begin
      tick_seen++;
      chk(!prev_tick, "R8", "tick high two cycles", 1, 0);
      if (exp_q.size() == 0) chk(1'b0, quiet_tag, "unexpected tick at edge", cyc, -1);
      else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cyc == e, t, "tick edge", cyc, e);
      end
    end
    prev_tick = tick;
  end

  function automatic logic [REG_W-1:0] cfg(input bit sel, input bit use_f, input int div);
    return {sel, use_f, 23'(div)};
  endfunction

  // First edge number beyond e+1 that carries an enable, then n-1 enables more.
  function automatic longint exp_edge(input longint e, input longint k, input longint n);
    longint m0;
    m0 = ((e + 1) / k + 1) * k;
    return m0 + (n - 1) * k;
  endfunction

  task automatic bus_wr(input logic en, input logic [7:0] a, input logic [REG_W-1:0] d,
                        output longint e);
    @(negedge clk);
    wr_en = en; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    e = cyc;
  endtask

  task automatic push(input longint e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic quiet(input string t, input int n);
    int s;
    quiet_tag = t;
    s = tick_seen;
    repeat (n) @(negedge clk);
    chk(tick_seen == s, t, "ticks while disabled", tick_seen - s, 0);
  endtask

  task automatic run_case(input bit sel, input int div, input longint k, input int pre,
                          input int nt, input string t);
    longint e;
    longint n;
    longint first;
    bus_wr(1'b1, ADDR, cfg(sel, 1'b1, div), e);
    n = longint'(pre) * (div + 1);
    first = exp_edge(e, k, n);
    push(first, "R7");
    for (int i = 1; i < nt; i++) push(first + i * n * k, t);
    drain();
    bus_wr(1'b1, ADDR, cfg(sel, 1'b0, div), e);
    quiet("R11", 80);
  endtask

  initial begin : main
    longint e;
    longint t1;
    longint tb;
    longint f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data == '0, "R1", "readback in reset", rd_data, 0);
    chk(tick == 1'b0, "R1", "tick in reset", tick, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(rd_data == '0, "R1", "readback after reset", rd_data, 0);

    // R2 field layout and readback
    bus_wr(1'b1, ADDR, 25'h07FFFFF, e);
    chk(rd_data == 25'h07FFFFF, "R2", "readback full divisor", rd_data, 25'h07FFFFF);
    bus_wr(1'b1, ADDR, 25'h1555555, e);
    chk(rd_data == 25'h1555555, "R2", "readback with select", rd_data, 25'h1555555);

    // R3 ignored writes
    bus_wr(1'b1, 8'h10, 25'h0ABCDEF, e);
    chk(rd_data == 25'h1555555, "R3", "other address", rd_data, 25'h1555555);
    bus_wr(1'b1, 8'h15, 25'h0ABCDEF, e);
    chk(rd_data == 25'h1555555, "R3", "neighbour address", rd_data, 25'h1555555);
    bus_wr(1'b0, ADDR, 25'h0123456, e);
    chk(rd_data == 25'h1555555, "R3", "strobe low", rd_data, 25'h1555555);

    // R4 disabled with both sources toggling every cycle
    km = 1; kx = 1;
    bus_wr(1'b1, ADDR, cfg(1'b0, 1'b0, 0), e);
    quiet("R4", 150);
    bus_wr(1'b1, ADDR, cfg(1'b1, 1'b0, 0), e);
    quiet("R4", 150);

    // R5 main path, continuous and sparse enables
    km = 1; run_case(1'b0, 2, 1, 4, 4, "R5");
    km = 2; run_case(1'b0, 5, 2, 4, 3, "R5");
    // R10 divisor zero on both paths
    km = 1; run_case(1'b0, 0, 1, 4, 4, "R10");
    kx = 3; km = 1; run_case(1'b1, 0, 3, 3, 3, "R10");
    // R6 crystal path with main enables ignored
    kx = 3; km = 1; run_case(1'b1, 3, 3, 3, 3, "R6");
    kx = 2; km = 1; run_case(1'b1, 7, 2, 3, 2, "R6");

    // R9 changes land at the tick boundary
    km = 1; kx = 3;
    bus_wr(1'b1, ADDR, cfg(1'b0, 1'b1, 3), e);
    t1 = e + 1 + 16;
    push(t1, "R7");
    drain();
    bus_wr(1'b1, ADDR, cfg(1'b0, 1'b1, 1), e);
    push(t1 + 16, "R9");
    push(t1 + 24, "R9");
    push(t1 + 32, "R9");
    drain();
    bus_wr(1'b1, ADDR, cfg(1'b1, 1'b1, 0), e);
    tb = t1 + 40;
    push(tb, "R9");
    f = exp_edge(tb - 1, 3, 3);
    push(f, "R9");
    push(f + 9, "R9");
    drain();
    bus_wr(1'b1, ADDR, cfg(1'b1, 1'b0, 0), e);
    quiet("R11", 60);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung, pending ticks actual %0d expected 0", exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule